// File: doc/BRIEF.md
# Store-Direct Bus Cycle Sequencer

This block produces the external bus activity of an 8-bit processor instruction that writes a 16-bit register pair to a direct memory address. The bus has shared lines: one 8-bit group carries the low address byte at the start of each machine cycle and data after that. The high address byte has its own lines. The block issues five machine cycles in a fixed order:

1. An opcode fetch of four T-states.
2. A three-T-state read of the low byte of the target address.
3. A three-T-state read of the high byte of the target address.
4. A three-T-state write of the low register to the target address.
5. A three-T-state write of the high register to the target address plus one.

The whole instruction therefore spans sixteen T-states, one clock each. The address-latch strobe is high only in T1. In that state the shared lines hold the low address byte, so an external latch captures the address on the falling edge of the strobe.

The surrounding core pulses `start` with the two register values present. The block fetches through its own program counter and captures the two operand bytes from `rd_data`. A bus-hold request is honoured at the end of a T3. The block then raises `hlda` and releases every bus output. It picks up the sequence where it stopped once the request is withdrawn. A `done` pulse marks the end of the instruction.

Top module: `sdbus_seq`

## Requirements
- R1: After a synchronous reset (`rst` high), `mcycle`=0, `tstate`=0, `hlda`=0, `done`=0, `bus_oe`=0, `ale`=0 and `rd_n`=`wr_n`=1.
- R2: `start` sampled high while idle makes the next clock M1 T1. The states then run M1 T1..T4, M2 T1..T3, M3 T1..T3, M4 T1..T3, M5 T1..T3, one per clock (`mcycle` 1..5, `tstate` 1..4). A `start` pulse while a sequence is running has no effect.
- R3: `ale` is 1 only in T1 of each machine cycle. In T1, `ad_out` carries the low address byte with `ad_oe`=1. In T1..T3, `addr_hi` carries the high address byte.
- R4: In M1, M2 and M3, `rd_n` is 0 in T2 and T3 with `ad_oe`=0. The clock edge that ends T3 of M2 captures `rd_data` as the target low byte, and the edge that ends T3 of M3 captures it as the target high byte.
- R5: M1, M2 and M3 are addressed by a 16-bit program counter. The counter is PC_INIT after reset and increases by one at the end of each of those three cycles, and its value carries over from one instruction to the next.
- R6: In M4 and M5, `wr_n` is 0 in T2 and T3 with `ad_oe`=1. `ad_out` carries the low register value in M4 and the high register value in M5, both as sampled when `start` was taken.
- R7: M4 is addressed at the captured target. M5 is addressed at the target plus one, with the carry into the high byte and a wrap from FFFF to 0000.
- R8: `done` is 1 for exactly the one clock that follows T3 of M5, and `mcycle` is 0 in that clock.
- R9: `hold` is acted on only when sampled high in T3 of M1..M4. The next clock is then a hold state with `hlda`=1, `bus_oe`=0, `ale`=0, `ad_oe`=0, `rd_n`=`wr_n`=1, `addr_hi`=`ad_out`=0, `tstate`=0, and `mcycle` still showing the cycle just finished. A request raised earlier in the cycle leaves T1 and T2 unchanged.
- R10: In the clock after `hold` is sampled low in the hold state, `hlda` is 0 and the sequence continues at the state that follows that T3 (T4 for M1, otherwise T1 of the next cycle).
- R11: `hold` has no effect while the block is idle: `hlda` stays 0.
- R12: Reset during a sequence or during a hold state returns the block to the R1 state, and the program counter returns to PC_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a store-direct instruction (taken while idle) |
| hold | input | 1 | Bus-hold request |
| reg_h | input | 8 | High register value |
| reg_l | input | 8 | Low register value |
| rd_data | input | 8 | Read data from memory |
| ale | output | 1 | Address-latch strobe, high in T1 |
| addr_hi | output | 8 | Dedicated high address byte |
| ad_out | output | 8 | Shared low-address / write-data lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Drive enable for address and strobes |
| hlda | output | 1 | Hold acknowledge |
| mcycle | output | 3 | Machine cycle number, 0 when idle |
| tstate | output | 3 | T-state number, 0 when idle or held |
| done | output | 1 | One-clock end-of-instruction pulse |

## Verification
The store sequence is run with distinct operand pairs and register values, so that a swapped low and high byte or a swapped register shows up on the bus. A low byte of FF and a target of FFFF separate a correct 16-bit increment from an 8-bit one or one without wrap. Hold requests are placed at the end of the fetch, of the high-byte read and of the first write, and with different lengths, which checks where the sequence resumes. One request is raised at T1, so a sequencer that acts on hold before T3 is caught. A reset during hold and a hold while idle check that nothing outlives the sequence.

// File: rtl/sdbus_pkg.sv
`timescale 1ns/1ps
package sdbus_pkg;

   typedef enum logic [2:0] {
      MC_IDLE  = 3'd0,
      MC_FETCH = 3'd1,
      MC_ADLO  = 3'd2,
      MC_ADHI  = 3'd3,
      MC_WRLO  = 3'd4,
      MC_WRHI  = 3'd5
   } mcyc_e;

   typedef logic [2:0] tst_t;

   localparam tst_t TS_NONE = 3'd0;
   localparam tst_t TS_T1   = 3'd1;
   localparam tst_t TS_T2   = 3'd2;
   localparam tst_t TS_T3   = 3'd3;
   localparam tst_t TS_T4   = 3'd4;

   typedef struct packed {
      mcyc_e mc;
      tst_t  ts;
   } pos_t;

   // successor of a bus position when no hold intervenes
   function automatic pos_t pos_next(input pos_t p);
      pos_t n;
      n = p;
      if (p.ts == TS_T3 && p.mc == MC_FETCH) begin
         n.ts = TS_T4;
      end else if (p.ts == TS_T4) begin
         n.mc = MC_ADLO;
         n.ts = TS_T1;
      end else if (p.ts == TS_T3 && p.mc == MC_WRHI) begin
         n.mc = MC_IDLE;
         n.ts = TS_NONE;
      end else if (p.ts == TS_T3) begin
         n.mc = mcyc_e'(p.mc + 3'd1);
         n.ts = TS_T1;
      end else begin
         n.ts = p.ts + 3'd1;
      end
      return n;
   endfunction

   function automatic logic is_read_cycle(input mcyc_e m);
      return (m == MC_FETCH) || (m == MC_ADLO) || (m == MC_ADHI);
   endfunction

   function automatic logic is_write_cycle(input mcyc_e m);
      return (m == MC_WRLO) || (m == MC_WRHI);
   endfunction

endpackage

// File: rtl/sdbus_timing.sv
`timescale 1ns/1ps
module sdbus_timing
   import sdbus_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic hold,
   output pos_t pos,
   output logic in_hold,
   output logic done,
   output logic launch,
   output logic fetch_end,
   output logic lo_cap,
   output logic hi_cap
);

   pos_t resume_q;
   logic at_t3;
   logic last_t3;

   assign at_t3     = (pos.mc != MC_IDLE) && !in_hold && (pos.ts == TS_T3);
   assign last_t3   = at_t3 && (pos.mc == MC_WRHI);
   assign launch    = (pos.mc == MC_IDLE) && start;
   assign fetch_end = at_t3 && is_read_cycle(pos.mc);
   assign lo_cap    = at_t3 && (pos.mc == MC_ADLO);
   assign hi_cap    = at_t3 && (pos.mc == MC_ADHI);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos      <= '{mc: MC_IDLE, ts: TS_NONE};
         resume_q <= '{mc: MC_IDLE, ts: TS_NONE};
         in_hold  <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= last_t3;
         if (in_hold) begin
            if (!hold) begin
               in_hold <= 1'b0;
               pos     <= resume_q;
            end
         end else if (launch) begin
            pos <= '{mc: MC_FETCH, ts: TS_T1};
         end else if (pos.mc != MC_IDLE) begin
            if (at_t3 && hold && !last_t3) begin
               in_hold  <= 1'b1;
               resume_q <= pos_next(pos);
            end else begin
               pos <= pos_next(pos);
            end
         end
      end
   end

endmodule

// File: rtl/sdbus_addr.sv
`timescale 1ns/1ps
module sdbus_addr
   import sdbus_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int PC_INIT = 0,
   localparam int ADDR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              launch,
   input  logic              fetch_end,
   input  logic              lo_cap,
   input  logic              hi_cap,
   input  mcyc_e             mc,
   input  logic [DATA_W-1:0] reg_h,
   input  logic [DATA_W-1:0] reg_l,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic [DATA_W-1:0] wr_byte
);

   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(PC_INIT);

   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] tgt_lo_q;
   logic [DATA_W-1:0] tgt_hi_q;
   logic [DATA_W-1:0] h_q;
   logic [DATA_W-1:0] l_q;
   logic [ADDR_W-1:0] tgt;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q     <= PC_RST;
         tgt_lo_q <= '0;
         tgt_hi_q <= '0;
         h_q      <= '0;
         l_q      <= '0;
      end else begin
         if (fetch_end) pc_q <= pc_q + ADDR_W'(1);
         if (lo_cap) tgt_lo_q <= rd_data;
         if (hi_cap) tgt_hi_q <= rd_data;
         if (launch) begin
            h_q <= reg_h;
            l_q <= reg_l;
         end
      end
   end

   assign tgt = {tgt_hi_q, tgt_lo_q};

   always_comb begin
      unique case (mc)
         MC_WRLO: cyc_addr = tgt;
         MC_WRHI: cyc_addr = tgt + ADDR_W'(1);
         default: cyc_addr = pc_q;
      endcase
   end

   assign wr_byte = (mc == MC_WRHI) ? h_q : l_q;

endmodule

// File: rtl/sdbus_drive.sv
`timescale 1ns/1ps
module sdbus_drive
   import sdbus_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit RELEASE_ONES = 1'b0,
   localparam int ADDR_W = 2 * DATA_W
) (
   input  pos_t              pos,
   input  logic              in_hold,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              ale,
   output logic [DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              rd_n,
   output logic              wr_n,
   output logic              bus_oe,
   output logic              hlda,
   output logic [2:0]        mcycle,
   output logic [2:0]        tstate
);

   logic [DATA_W-1:0] rel_val;
   logic              active;
   logic              strobe_t;
   logic              rd_ph;
   logic              wr_ph;

   generate
      if (RELEASE_ONES) begin : g_rel_ones
         assign rel_val = '1;
      end else begin : g_rel_zero
         assign rel_val = '0;
      end
   endgenerate

   assign active   = (pos.mc != MC_IDLE) && !in_hold;
   assign strobe_t = (pos.ts == TS_T2) || (pos.ts == TS_T3);
   assign rd_ph    = active && strobe_t && is_read_cycle(pos.mc);
   assign wr_ph    = active && strobe_t && is_write_cycle(pos.mc);

   assign ale     = active && (pos.ts == TS_T1);
   assign bus_oe  = active;
   assign hlda    = in_hold;
   assign rd_n    = !rd_ph;
   assign wr_n    = !wr_ph;
   assign ad_oe   = ale || wr_ph;
   assign addr_hi = active ? cyc_addr[ADDR_W-1:DATA_W] : rel_val;
   assign ad_out  = ale   ? cyc_addr[DATA_W-1:0] :
                    wr_ph ? wr_byte : rel_val;
   assign mcycle  = pos.mc;
   assign tstate  = active ? pos.ts : TS_NONE;

endmodule

// File: rtl/sdbus_seq.sv
`timescale 1ns/1ps
module sdbus_seq
   import sdbus_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int PC_INIT      = 0,
   parameter bit RELEASE_ONES = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              hold,
   input  logic [DATA_W-1:0] reg_h,
   input  logic [DATA_W-1:0] reg_l,
   input  logic [DATA_W-1:0] rd_data,
   output logic              ale,
   output logic [DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              rd_n,
   output logic              wr_n,
   output logic              bus_oe,
   output logic              hlda,
   output logic [2:0]        mcycle,
   output logic [2:0]        tstate,
   output logic              done
);

   localparam int ADDR_W = 2 * DATA_W;

   generate
      if (DATA_W < 4 || DATA_W > 16) begin : g_bad_width
         $error("sdbus_seq: DATA_W must lie in 4..16");
      end
      if (PC_INIT < 0 || PC_INIT >= (1 << ADDR_W)) begin : g_bad_pc
         $error("sdbus_seq: PC_INIT does not fit the address width");
      end
   endgenerate

   pos_t              pos;
   logic              in_hold;
   logic              launch;
   logic              fetch_end;
   logic              lo_cap;
   logic              hi_cap;
   logic [ADDR_W-1:0] cyc_addr;
   logic [DATA_W-1:0] wr_byte;

   sdbus_timing u_timing (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .hold      (hold),
      .pos       (pos),
      .in_hold   (in_hold),
      .done      (done),
      .launch    (launch),
      .fetch_end (fetch_end),
      .lo_cap    (lo_cap),
      .hi_cap    (hi_cap)
   );

   sdbus_addr #(
      .DATA_W  (DATA_W),
      .PC_INIT (PC_INIT)
   ) u_addr (
      .clk       (clk),
      .rst       (rst),
      .launch    (launch),
      .fetch_end (fetch_end),
      .lo_cap    (lo_cap),
      .hi_cap    (hi_cap),
      .mc        (pos.mc),
      .reg_h     (reg_h),
      .reg_l     (reg_l),
      .rd_data   (rd_data),
      .cyc_addr  (cyc_addr),
      .wr_byte   (wr_byte)
   );

   sdbus_drive #(
      .DATA_W       (DATA_W),
      .RELEASE_ONES (RELEASE_ONES)
   ) u_drive (
      .pos      (pos),
      .in_hold  (in_hold),
      .cyc_addr (cyc_addr),
      .wr_byte  (wr_byte),
      .ale      (ale),
      .addr_hi  (addr_hi),
      .ad_out   (ad_out),
      .ad_oe    (ad_oe),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .bus_oe   (bus_oe),
      .hlda     (hlda),
      .mcycle   (mcycle),
      .tstate   (tstate)
   );

endmodule

// File: rtl/sdbus_seq_chk.sv
`timescale 1ns/1ps
module sdbus_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       hold,
   input logic       ale,
   input logic       ad_oe,
   input logic       rd_n,
   input logic       wr_n,
   input logic       bus_oe,
   input logic       hlda,
   input logic [2:0] mcycle,
   input logic [2:0] tstate,
   input logic       done
);

   p_ale_in_t1_r3: assert property (@(posedge clk) disable iff (rst)
      ale |-> (tstate == 3'd1) && bus_oe && ad_oe);

   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
      rd_n || wr_n);

   p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (rst)
      (tstate == 3'd2) |=> (tstate == 3'd3));

   p_fetch_t4_r2: assert property (@(posedge clk) disable iff (rst)
      (mcycle == 3'd1 && tstate == 3'd3 && !hold) |=> (tstate == 3'd4));

   p_done_after_m5_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(mcycle) == 3'd5) && ($past(tstate) == 3'd3) && (mcycle == 3'd0));

   p_hold_released_r9: assert property (@(posedge clk) disable iff (rst)
      hlda |-> !bus_oe && !ale && !ad_oe && rd_n && wr_n && (tstate == 3'd0));

   p_hold_entry_t3_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(hlda) |-> ($past(tstate) == 3'd3) && $past(hold));

   p_hold_exit_r10: assert property (@(posedge clk) disable iff (rst)
      (hlda && !hold) |=> !hlda && bus_oe);

   p_idle_no_hlda_r11: assert property (@(posedge clk) disable iff (rst)
      (mcycle == 3'd0 && !hlda) |=> !hlda);

endmodule

bind sdbus_seq sdbus_seq_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .hold   (hold),
   .ale    (ale),
   .ad_oe  (ad_oe),
   .rd_n   (rd_n),
   .wr_n   (wr_n),
   .bus_oe (bus_oe),
   .hlda   (hlda),
   .mcycle (mcycle),
   .tstate (tstate),
   .done   (done)
);

// File: tb/tb_sdbus_seq.sv
`timescale 1ns/1ps
module tb_sdbus_seq;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       hold = 1'b0;
   logic [7:0] reg_h = 8'h00;
   logic [7:0] reg_l = 8'h00;
   logic [7:0] rd_data = 8'h00;
   logic       ale, ad_oe, rd_n, wr_n, bus_oe, hlda, done;
   logic [7:0] addr_hi, ad_out;
   logic [2:0] mcycle, tstate;

   int checks = 0;
   int fails = 0;
   logic [15:0] exp_pc = 16'h0000;

   always #10 clk = ~clk;

   sdbus_seq dut (
      .clk(clk), .rst(rst), .start(start), .hold(hold),
      .reg_h(reg_h), .reg_l(reg_l), .rd_data(rd_data),
      .ale(ale), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
      .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe), .hlda(hlda),
      .mcycle(mcycle), .tstate(tstate), .done(done)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, "idle mcycle/tstate/hlda/done", {mcycle, tstate, hlda, done}, 8'h00);
      chk(req, "idle bus_oe/ale/rd_n/wr_n", {bus_oe, ale, rd_n, wr_n}, 4'b0011);
   endtask

   task automatic chk_tstate(input int m, input int t, input logic [15:0] a,
                             input logic [7:0] l, input logic [7:0] h);
      logic rd_e, wr_e;
      rd_e = (m <= 3) && (t == 2 || t == 3);
      wr_e = (m >= 4) && (t == 2 || t == 3);
      chk("R2", "mcycle/tstate", {mcycle, tstate}, {3'(m), 3'(t)});
      chk("R3", "ale", ale, (t == 1));
      chk("R4 R6", "rd_n/wr_n/ad_oe", {rd_n, wr_n, ad_oe}, {!rd_e, !wr_e, (t == 1) || wr_e});
      chk("R9", "hlda/bus_oe", {hlda, bus_oe}, 2'b01);
      if (t != 4) chk("R3 R5 R7", "addr_hi", addr_hi, a[15:8]);
      if (t == 1) chk("R3 R5 R7", "ad_out low address", ad_out, a[7:0]);
      else if (wr_e) chk("R6", "ad_out write data", ad_out, (m == 4) ? l : h);
   endtask

   task automatic chk_held(input int m);
      chk("R9", "hold hlda/bus_oe/ale/ad_oe", {hlda, bus_oe, ale, ad_oe}, 4'b1000);
      chk("R9", "hold strobes", {rd_n, wr_n}, 2'b11);
      chk("R9", "hold mcycle/tstate", {mcycle, tstate}, {3'(m), 3'd0});
      chk("R9", "hold lines idle", {addr_hi, ad_out}, 16'h0000);
   endtask

   // one store-direct instruction; hold_mc selects the cycle whose T3 meets a
   // hold request (0 = none); early raises it at T1 of that cycle
   task automatic run_store(input logic [7:0] h, input logic [7:0] l,
                            input logic [7:0] lo, input logic [7:0] hi,
                            input int hold_mc, input bit early, input int hold_len,
                            input bit mid_start);
      logic [15:0] tgt, a;
      tgt = {hi, lo};
      @(negedge clk);
      start = 1'b1; reg_h = h; reg_l = l;
      @(negedge clk);
      start = 1'b0; reg_h = ~h; reg_l = ~l;
      for (int m = 1; m <= 5; m++) begin
         for (int t = 1; t <= ((m == 1) ? 4 : 3); t++) begin
            rd_data = (m == 2) ? lo : (m == 3) ? hi : 8'h22;
            start = mid_start && (m == 2) && (t == 2);
            if (hold_mc == m && (early || t == 3)) hold = 1'b1;
            a = (m <= 3) ? exp_pc + 16'(m - 1) : (m == 4) ? tgt : tgt + 16'h1;
            chk_tstate(m, t, a, l, h);
            if (t == 3 && hold_mc == m && m < 5) begin
               for (int k = 0; k < hold_len; k++) begin
                  @(negedge clk);
                  chk_held(m);
                  if (k == hold_len - 1) hold = 1'b0;
               end
            end
            @(negedge clk);
         end
      end
      start = 1'b0;
      chk("R8", "done after M5 T3", {done, mcycle}, {1'b1, 3'd0});
      @(negedge clk);
      chk("R8", "done single pulse", done, 1'b0);
      exp_pc = exp_pc + 16'd3;
   endtask

   task automatic test_reset_state();
      chk_idle("R1");
   endtask

   task automatic test_idle_hold();
      @(negedge clk);
      hold = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11", "hlda while idle", {hlda, bus_oe, mcycle}, 5'b0);
      hold = 1'b0;
      @(negedge clk);
   endtask

   task automatic test_reset_in_hold();
      @(negedge clk);
      start = 1'b1; reg_h = 8'h99; reg_l = 8'h88;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);     // now M2 T3
      chk("R2", "reach M2 T3", {mcycle, tstate}, {3'd2, 3'd3});
      hold = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9", "held before reset", hlda, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_idle("R12");
      @(negedge clk);
      chk("R11 R12", "hold after reset ignored", hlda, 1'b0);
      hold = 1'b0;
      exp_pc = 16'h0000;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset_state();
      rst = 1'b0;
      @(negedge clk);
      test_reset_state();
      run_store(8'h12, 8'h34, 8'h56, 8'h78, 0, 1'b0, 0, 1'b1);
      run_store(8'hA1, 8'hB2, 8'hFF, 8'h20, 1, 1'b0, 3, 1'b0);
      run_store(8'h5A, 8'hC3, 8'h10, 8'h40, 3, 1'b1, 1, 1'b0);
      run_store(8'hE7, 8'h7E, 8'hFF, 8'hFF, 4, 1'b0, 2, 1'b0);
      test_idle_hold();
      test_reset_in_hold();
      run_store(8'h01, 8'h02, 8'h03, 8'h04, 2, 1'b0, 1, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule